// File: doc/BRIEF.md
# Dual-Channel Memory Copy Engine

This block moves data from one memory address to another on behalf of software, so the processor does not have to copy it word by word. It has two channels. Each channel holds its own source pointer, destination pointer, 16-bit beat count and beat width. A channel starts either when software writes a trigger command or while an external request line is high. The block is the only master on a simple valid/ready memory bus. For every beat it reads from the source and then writes the same data to the destination.

When both channels want the bus, a small arbiter chooses between them. The choice follows either a fixed order or a rotating order, selected by one global mode bit. Each channel also selects how long it keeps the bus. In steal mode it gives the bus up after every beat, so the arbiter chooses again. In burst mode it keeps the bus until its count reaches zero. When a channel finishes, it drives a one-cycle completion pulse and raises a sticky interrupt. Software clears that interrupt with a command write.

Top module: `dma_dual_channel`

## Requirements
- R1: Register offsets use `reg_addr[2:0]`, and `reg_addr[3]` selects the channel. Offset 0 is the source pointer, 1 the destination pointer, 2 the count and 3 the control word. Control bits are [0] enable, [1] external-request select, [2] burst, [4:3] width and [5] hold-addresses; on read, bit 6 shows the interrupt. Offset 4 is a write-only command: bit 0 triggers, bit 1 clears the interrupt. Offset 7 in either half is the global mode: bit 0 set means rotating. Written values read back, and everything reads as zero after reset.
- R2: A beat is one bus read from the source pointer followed by one bus write of the same data to the destination pointer. A triggered channel performs exactly as many beats as its count.
- R3: A channel with external-request select set moves data only while its external request line is high. A software trigger to that channel has no effect.
- R4: In fixed mode, when both channels request at the same arbitration, channel 0 is granted.
- R5: In rotating mode, when both channels request, the channel not granted last is granted. After reset, channel 0 counts as next.
- R6: A channel in steal mode leaves the bus idle for one cycle after each beat, so the arbiter chooses again. A channel in burst mode starts its next read directly after each write until its count is zero.
- R7: When a channel's transfers end, its completion output is high for exactly one cycle. Its interrupt output stays set until a clear command, and its enable bit reads back as 0.
- R8: Width code 0, 1 or 2 selects 1, 2 or 4 bytes. The code appears on `bus_size`, and both pointers advance by that byte count after each beat.
- R9: With hold-addresses set, both pointers stay at their programmed values during the whole transfer.
- R10: Enabling a channel with a count of zero causes no bus cycle. The completion pulse appears on the second clock edge after the control write.
- R11: A bus cycle holds its address and direction until `bus_ready` is sampled high. The count is decremented only when the write cycle completes.
- R12: The count register is 16 bits wide (maximum 65,535). Bits above 15 of a count write are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address: bit 3 selects the channel, bits 2:0 the offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| ext_req | input | 2 | External request line per channel |
| bus_valid | output | 1 | Bus cycle active |
| bus_we | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_addr | output | AW | Byte address of the bus cycle |
| bus_size | output | 2 | Width code of the cycle (0 byte, 1 half, 2 word) |
| bus_wdata | output | DW | Write data, little-endian in the low lanes |
| bus_rdata | input | DW | Read data, valid with `bus_ready` on read cycles |
| bus_ready | input | 1 | Memory completes the current cycle |
| done | output | 2 | One-cycle completion pulse per channel |
| irq | output | 2 | Sticky interrupt per channel |

## Verification
The assertions take three things for granted about the inputs. Software does not write to a channel while it is moving data. Memory eventually returns `bus_ready` for every cycle. Only width codes 0 to 2 are used. The stimulus keeps to all three: registers are written only while every channel is idle or disabled, and a memory model drives ready after a bounded, programmable number of wait cycles. The channels' regions never overlap, so the owner of each write can be read from its address when grant order is checked.

// File: rtl/dma2_pkg.sv
// Package: shared state encoding, register offsets and width helper for
// the dual-channel copy engine. Assumes width codes 0..2.
package dma2_pkg;

    typedef enum logic [1:0] {
        MV_IDLE  = 2'd0,
        MV_READ  = 2'd1,
        MV_WRITE = 2'd2
    } mv_state_t;

    localparam logic [2:0] OFF_SRC  = 3'd0;
    localparam logic [2:0] OFF_DST  = 3'd1;
    localparam logic [2:0] OFF_CNT  = 3'd2;
    localparam logic [2:0] OFF_CTRL = 3'd3;
    localparam logic [2:0] OFF_CMD  = 3'd4;
    localparam logic [2:0] OFF_MODE = 3'd7;

    // Byte count of one beat for a width code.
    function automatic logic [2:0] step_of(input logic [1:0] sz);
        case (sz)
            2'd0:    step_of = 3'd1;
            2'd1:    step_of = 3'd2;
            default: step_of = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dma2_chan.sv
// Module: per-channel register set and state. Holds the pointers, count
// and control fields, decides when the channel asks for the bus, and
// raises completion when an enabled channel reaches a zero count.
// Assumes no register write arrives while the channel is moving data.
module dma2_chan
    import dma2_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    wr_off,
    input  logic [31:0]   wr_data,
    input  logic [2:0]    rd_off,
    input  logic          ext_req,
    input  logic          beat,
    output logic [AW-1:0] src_q,
    output logic [AW-1:0] dst_q,
    output logic [CW-1:0] cnt_q,
    output logic [1:0]    size_q,
    output logic          burst_q,
    output logic          chreq,
    output logic          done,
    output logic          irq,
    output logic [31:0]   rd_data
);

    logic          en_q;
    logic          ext_sel_q;
    logic          fix_q;
    logic          swp_q;
    logic [AW-1:0] step_w;

    // Pointer advance per beat; zero when addresses are held.
    assign step_w = fix_q ? '0 : AW'(step_of(size_q));

    // Bus request: enabled, work left, and the selected trigger present.
    assign chreq = en_q && (cnt_q != '0) && (ext_sel_q ? ext_req : swp_q);

    // Register state update: beats, completion, then software writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q     <= '0;
            dst_q     <= '0;
            cnt_q     <= '0;
            size_q    <= '0;
            burst_q   <= 1'b0;
            en_q      <= 1'b0;
            ext_sel_q <= 1'b0;
            fix_q     <= 1'b0;
            swp_q     <= 1'b0;
            done      <= 1'b0;
            irq       <= 1'b0;
        end else begin
            done <= 1'b0;
            if (beat) begin
                src_q <= src_q + step_w;
                dst_q <= dst_q + step_w;
                cnt_q <= cnt_q - CW'(1);
            end
            if (en_q && (cnt_q == '0)) begin
                done  <= 1'b1;
                irq   <= 1'b1;
                en_q  <= 1'b0;
                swp_q <= 1'b0;
            end
            if (wr_en) begin
                case (wr_off)
                    OFF_SRC: src_q <= wr_data[AW-1:0];
                    OFF_DST: dst_q <= wr_data[AW-1:0];
                    OFF_CNT: cnt_q <= wr_data[CW-1:0];
                    OFF_CTRL: begin
                        en_q      <= wr_data[0];
                        ext_sel_q <= wr_data[1];
                        burst_q   <= wr_data[2];
                        size_q    <= wr_data[4:3];
                        fix_q     <= wr_data[5];
                    end
                    OFF_CMD: begin
                        if (wr_data[0]) swp_q <= 1'b1;
                        if (wr_data[1]) irq   <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Readback multiplexer for this channel's offsets.
    always_comb begin
        case (rd_off)
            OFF_SRC:  rd_data = 32'(src_q);
            OFF_DST:  rd_data = 32'(dst_q);
            OFF_CNT:  rd_data = 32'(cnt_q);
            OFF_CTRL: rd_data = {25'd0, irq, fix_q, size_q, burst_q, ext_sel_q, en_q};
            default:  rd_data = '0;
        endcase
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_NO_BEAT_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        beat |-> (cnt_q != '0)); // R10
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        beat && !wr_en |=> cnt_q == $past(cnt_q) - CW'(1)); // R11
    AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        beat && fix_q && !wr_en |=> $stable(src_q) && $stable(dst_q)); // R9

endmodule

// File: rtl/dma2_arb.sv
// Module: two-way bus arbiter. Grants only while the mover is idle.
// Fixed mode favours channel 0; rotating mode favours the channel not
// granted last. Assumes requests are level signals held until served.
module dma2_arb (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rr_mode,
    input  logic       open,
    input  logic [1:0] req,
    output logic [1:0] gnt
);

    logic last_q; // index of the channel granted most recently

    // Grant selection for the current idle cycle.
    always_comb begin
        gnt = 2'b00;
        if (open) begin
            if (req == 2'b11)
                gnt = (rr_mode && !last_q) ? 2'b10 : 2'b01;
            else
                gnt = req;
        end
    end

    // Remember the last winner for rotation.
    always_ff @(posedge clk) begin
        if (!rst_n)       last_q <= 1'b1;
        else if (gnt[0])  last_q <= 1'b0;
        else if (gnt[1])  last_q <= 1'b1;
    end

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt)); // R4
    AST_GNT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == 2'b00); // R2
    AST_FIXED_CH0: assert property (@(posedge clk) disable iff (!rst_n)
        !rr_mode && open && (&req) |-> gnt[0]); // R4
    AST_RR_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        rr_mode && open && (&req) |-> !gnt[last_q]); // R5

endmodule

// File: rtl/dma2_mover.sv
// Module: bus sequencer. Takes a grant, reads one beat from the source,
// writes it to the destination, then either continues (burst) or returns
// to idle. Assumes memory eventually answers every cycle with ready.
module dma2_mover
    import dma2_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    gnt,
    input  logic [AW-1:0] src_a,
    input  logic [AW-1:0] dst_a,
    input  logic [1:0]    size,
    input  logic          keep,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_ready,
    output logic          open,
    output logic          cur_ch,
    output logic [1:0]    beat,
    output logic          bus_valid,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [1:0]    bus_size,
    output logic [DW-1:0] bus_wdata
);

    mv_state_t     state_q;
    logic          cur_q;
    logic [DW-1:0] data_q;

    // Beat sequencing: idle -> read -> write -> read or idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MV_IDLE;
            cur_q   <= 1'b0;
            data_q  <= '0;
        end else begin
            unique case (state_q)
                MV_IDLE: if (|gnt) begin
                    cur_q   <= gnt[1];
                    state_q <= MV_READ;
                end
                MV_READ: if (bus_ready) begin
                    data_q  <= bus_rdata;
                    state_q <= MV_WRITE;
                end
                MV_WRITE: if (bus_ready) begin
                    state_q <= keep ? MV_READ : MV_IDLE;
                end
                default: state_q <= MV_IDLE;
            endcase
        end
    end

    // Bus outputs and the per-channel beat-complete strobe.
    always_comb begin
        open      = (state_q == MV_IDLE);
        cur_ch    = cur_q;
        bus_valid = (state_q != MV_IDLE);
        bus_we    = (state_q == MV_WRITE);
        bus_addr  = bus_we ? dst_a : src_a;
        bus_size  = size;
        bus_wdata = data_q;
        beat      = 2'b00;
        if (state_q == MV_WRITE && bus_ready)
            beat = cur_q ? 2'b10 : 2'b01;
    end

    AST_HOLD_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_we)); // R11
    AST_WRITE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_we && bus_ready |=> bus_valid && bus_we); // R2
    AST_STEAL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && bus_we && bus_ready && !keep |=> !bus_valid); // R6

endmodule

// File: rtl/dma_dual_channel.sv
// Module: top of the dual-channel copy engine. Decodes the register
// window, holds the global arbitration mode, and steers the active
// channel's pointers into the bus sequencer.
// Assumes AW <= 32 and DW == 32; register writes only to idle channels.
module dma_dual_channel
    import dma2_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [3:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic [1:0]    ext_req,
    output logic          bus_valid,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [1:0]    bus_size,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_ready,
    output logic [1:0]    done,
    output logic [1:0]    irq
);

    localparam int NCH = 2;

    logic [2:0]    off;
    logic          sel_ch;
    logic          rr_q;
    logic [AW-1:0] src_a   [NCH];
    logic [AW-1:0] dst_a   [NCH];
    logic [CW-1:0] cnt_a   [NCH];
    logic [1:0]    size_a  [NCH];
    logic          burst_a [NCH];
    logic [31:0]   rd_a    [NCH];
    logic [NCH-1:0] chreq;
    logic [NCH-1:0] gnt;
    logic [NCH-1:0] beat;
    logic          open;
    logic          cur;
    logic          keep;

    assign off    = reg_addr[2:0];
    assign sel_ch = reg_addr[3];

    // Global arbitration mode register.
    always_ff @(posedge clk) begin
        if (!rst_n)                          rr_q <= 1'b0;
        else if (reg_we && off == OFF_MODE)  rr_q <= reg_wdata[0];
    end

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        dma2_chan #(.AW(AW), .CW(CW)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (reg_we && (sel_ch == 1'(g)) && (off != OFF_MODE)),
            .wr_off  (off),
            .wr_data (reg_wdata),
            .rd_off  (off),
            .ext_req (ext_req[g]),
            .beat    (beat[g]),
            .src_q   (src_a[g]),
            .dst_q   (dst_a[g]),
            .cnt_q   (cnt_a[g]),
            .size_q  (size_a[g]),
            .burst_q (burst_a[g]),
            .chreq   (chreq[g]),
            .done    (done[g]),
            .irq     (irq[g]),
            .rd_data (rd_a[g])
        );
    end

    // Register read path: mode word or the addressed channel.
    assign reg_rdata = (off == OFF_MODE) ? {31'd0, rr_q} : rd_a[sel_ch];

    // Burst continuation: active channel still wants the bus after this beat.
    assign keep = burst_a[cur] && chreq[cur] && (cnt_a[cur] != CW'(1));

    dma2_arb u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .rr_mode (rr_q),
        .open    (open),
        .req     (chreq),
        .gnt     (gnt)
    );

    dma2_mover #(.AW(AW), .DW(DW)) u_mover (
        .clk       (clk),
        .rst_n     (rst_n),
        .gnt       (gnt),
        .src_a     (src_a[cur]),
        .dst_a     (dst_a[cur]),
        .size      (size_a[cur]),
        .keep      (keep),
        .bus_rdata (bus_rdata),
        .bus_ready (bus_ready),
        .open      (open),
        .cur_ch    (cur),
        .beat      (beat),
        .bus_valid (bus_valid),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_size  (bus_size),
        .bus_wdata (bus_wdata)
    );

endmodule

// File: tb/tb_dma_dual_channel.sv
// Bench: table-driven single-channel copies, then directed tests for
// reset, registers, zero count, external request, priority and stalls.
module tb_dma_dual_channel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = 4'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic [1:0]  ext_req = 2'b00;
    logic        bus_valid, bus_we;
    logic [31:0] bus_addr;
    logic [1:0]  bus_size;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata = 32'd0;
    logic        bus_ready = 1'b0;
    logic [1:0]  done, irq;

    dma_dual_channel dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_req(ext_req),
        .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .done(done), .irq(irq)
    );

    always #5 clk = ~clk;

    // size[29:28] fix[27] burst[26] wait[25:24] cnt[23:16] src[15:8] dst[7:0]
    localparam logic [29:0] VECS [6] = '{
        {2'd0, 1'b0, 1'b1, 2'd0, 8'd5, 8'h00, 8'h80},
        {2'd1, 1'b0, 1'b0, 2'd0, 8'd4, 8'h10, 8'h90},
        {2'd2, 1'b0, 1'b1, 2'd2, 8'd3, 8'h20, 8'hA0},
        {2'd2, 1'b1, 1'b0, 2'd1, 8'd3, 8'h30, 8'hB0},
        {2'd0, 1'b0, 1'b0, 2'd3, 8'd6, 8'h40, 8'hC0},
        {2'd1, 1'b1, 1'b1, 2'd0, 8'd2, 8'h48, 8'hD0}
    };

    logic [7:0] mem   [256];
    logic [7:0] ref_m [256];
    logic [7:0] wr_log [64];
    int         wr_cyc [64];
    int         wr_beats = 0, valid_cycles = 0, cyc = 0, dn0 = 0, dn1 = 0;
    int         wait_cfg = 0, wcnt = 0, checks = 0, fails = 0;
    logic [1:0] seen_size = 2'd0;
    logic [7:0] ra;
    bit         finished = 0;

    // Bus monitor and memory write port.
    always @(posedge clk) begin
        cyc++;
        if (done[0]) dn0++;
        if (done[1]) dn1++;
        if (bus_valid) valid_cycles++;
        if (bus_valid && bus_ready && bus_we) begin
            mem[bus_addr[7:0]] = bus_wdata[7:0];
            if (bus_size >= 2'd1) mem[bus_addr[7:0] + 8'd1] = bus_wdata[15:8];
            if (bus_size >= 2'd2) begin
                mem[bus_addr[7:0] + 8'd2] = bus_wdata[23:16];
                mem[bus_addr[7:0] + 8'd3] = bus_wdata[31:24];
            end
            if (wr_beats < 64) begin
                wr_log[wr_beats] = bus_addr[7:0];
                wr_cyc[wr_beats] = cyc;
            end
            wr_beats++;
            seen_size = bus_size;
        end
    end

    // Memory read port and wait-state generator, driven off the active edge.
    always @(negedge clk) begin
        ra = bus_addr[7:0];
        bus_rdata = {mem[ra + 8'd3], mem[ra + 8'd2], mem[ra + 8'd1], mem[ra]};
        if (bus_valid) begin
            if (wcnt >= wait_cfg) begin bus_ready = 1'b1; wcnt = 0; end
            else begin bus_ready = 1'b0; wcnt++; end
        end else begin
            bus_ready = 1'b0;
            wcnt = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic fill_mem();
        for (int i = 0; i < 256; i++) begin
            mem[i]   = 8'(i * 37 + 11);
            ref_m[i] = 8'(i * 37 + 11);
        end
    endtask

    task automatic wait_both(input int b0, input int b1, input bit need0, input bit need1);
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if ((!need0 || dn0 > b0) && (!need1 || dn1 > b1)) break;
        end
    endtask

    function automatic logic [5:0] owner_seq();
        logic [5:0] s;
        for (int k = 0; k < 6; k++) s[k] = (wr_log[k] >= 8'hE0);
        return s;
    endfunction

    initial begin
        logic [31:0] d;
        logic [29:0] e;
        logic [1:0]  sz;
        logic        fx, bu;
        int          w, n, nb, stp, s, t, mis, b0, b1;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state (R1, R7)
        rd(4'h2, d);  chk(d == 0, "R1 reset count", d, 0);
        rd(4'h3, d);  chk(d == 0, "R1 reset ctrl", d, 0);
        rd(4'h7, d);  chk(d == 0, "R1 reset mode", d, 0);
        chk(done == 0 && irq == 0, "R7 reset done/irq", {done, irq}, 0);
        chk(bus_valid == 0, "R2 reset bus idle", bus_valid, 0);

        // Register readback and count width (R1, R12)
        wr(4'h8, 32'hDEADBEEF); rd(4'h8, d); chk(d == 32'hDEADBEEF, "R1 src readback", d, 32'hDEADBEEF);
        wr(4'hA, 32'h0001_2345); rd(4'hA, d); chk(d == 32'h2345, "R12 count upper bits dropped", d, 32'h2345);
        wr(4'hA, 32'h0000_FFFF); rd(4'hA, d); chk(d == 32'hFFFF, "R12 count max", d, 32'hFFFF);
        wr(4'hB, 32'h0000_001C); rd(4'hB, d); chk(d == 32'h1C, "R1 ctrl readback", d, 32'h1C);
        wr(4'hB, 32'h0); wr(4'hA, 32'h0);

        // Table-driven single-channel copies on channel 0 (R2, R6, R7, R8, R9, R11)
        for (int v = 0; v < 6; v++) begin
            e  = VECS[v];
            sz = e[29:28]; fx = e[27]; bu = e[26]; w = int'(e[25:24]);
            n  = int'(e[23:16]); s = int'(e[15:8]); t = int'(e[7:0]);
            nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
            stp = fx ? 0 : nb;
            fill_mem();
            for (int k = 0; k < n; k++)
                for (int b = 0; b < nb; b++)
                    ref_m[8'(t + k * stp + b)] = ref_m[8'(s + k * stp + b)];
            wait_cfg = w;
            wr(4'h7, 32'h0);
            wr(4'h0, 32'(s)); wr(4'h1, 32'(t)); wr(4'h2, 32'(n));
            wr(4'h3, {26'd0, fx, sz, bu, 1'b0, 1'b1});
            wr_beats = 0; b0 = dn0;
            wr(4'h4, 32'h1);
            wait_both(b0, 0, 1'b1, 1'b0);
            @(negedge clk);
            chk(dn0 == b0 + 1, "R7 one completion", dn0 - b0, 1);
            chk(wr_beats == n, "R2 beat count", wr_beats, n);
            mis = 0;
            for (int i = 0; i < 256; i++) if (mem[i] !== ref_m[i]) mis++;
            chk(mis == 0, "R2 copied data", mis, 0);
            chk(seen_size == sz, "R8 bus_size", seen_size, sz);
            rd(4'h0, d);
            if (fx) chk(d == 32'(s), "R9 source held", d, s);
            else    chk(d == 32'(s + n * stp), "R8 source advanced", d, s + n * stp);
            rd(4'h1, d);
            if (fx) chk(d == 32'(t), "R9 destination held", d, t);
            else    chk(d == 32'(t + n * stp), "R8 destination advanced", d, t + n * stp);
            rd(4'h2, d); chk(d == 0, "R11 count drained", d, 0);
            if (w == 0 && n >= 2)
                chk(wr_cyc[1] - wr_cyc[0] == (bu ? 2 : 3), "R6 beat spacing",
                    wr_cyc[1] - wr_cyc[0], bu ? 2 : 3);
            rd(4'h3, d);
            chk(irq[0] == 1'b1 && d[6] == 1'b1 && d[0] == 1'b0, "R7 irq set, enable cleared", d, 32'h40);
            wr(4'h4, 32'h2);
            chk(irq[0] == 1'b0, "R7 irq cleared", irq[0], 0);
        end
        wait_cfg = 0;

        // Zero count: completion on second edge, no bus cycle (R10)
        wr(4'h2, 32'h0);
        b0 = valid_cycles;
        wr(4'h3, 32'h1);
        chk(done[0] == 1'b0, "R10 no completion yet", done[0], 0);
        @(negedge clk);
        chk(done[0] == 1'b1, "R10 completion pulse", done[0], 1);
        @(negedge clk);
        chk(done[0] == 1'b0, "R7 pulse one cycle", done[0], 0);
        chk(valid_cycles == b0, "R10 no bus cycle", valid_cycles - b0, 0);
        wr(4'h4, 32'h2);

        // External request select gates the channel; software trigger ignored (R3)
        fill_mem();
        wr(4'h8, 32'h04); wr(4'h9, 32'hF0); wr(4'hA, 32'd3);
        wr(4'hB, 32'h3);
        wr_beats = 0;
        wr(4'hC, 32'h1);
        repeat (20) @(negedge clk);
        chk(wr_beats == 0, "R3 no beats without external request", wr_beats, 0);
        rd(4'hA, d); chk(d == 3, "R3 count untouched", d, 3);
        b1 = dn1;
        ext_req = 2'b10;
        wait_both(0, b1, 1'b0, 1'b1);
        ext_req = 2'b00;
        chk(wr_beats == 3, "R3 beats with external request", wr_beats, 3);
        wr(4'hC, 32'h2);

        // Fixed priority, both in steal mode (R4)
        wr(4'h7, 32'h0);
        wr(4'h0, 32'h00); wr(4'h1, 32'h60); wr(4'h2, 32'd3); wr(4'h3, 32'h3);
        wr(4'h8, 32'h10); wr(4'h9, 32'hE0); wr(4'hA, 32'd3); wr(4'hB, 32'h3);
        wr_beats = 0; b0 = dn0; b1 = dn1;
        ext_req = 2'b11;
        wait_both(b0, b1, 1'b1, 1'b1);
        ext_req = 2'b00;
        chk(owner_seq() == 6'b111000, "R4 fixed order", owner_seq(), 6'b111000);

        // Rotating priority, both in steal mode (R5)
        wr(4'h7, 32'h1);
        wr(4'h0, 32'h00); wr(4'h1, 32'h60); wr(4'h2, 32'd3); wr(4'h3, 32'h3);
        wr(4'h8, 32'h10); wr(4'h9, 32'hE0); wr(4'hA, 32'd3); wr(4'hB, 32'h3);
        wr_beats = 0; b0 = dn0; b1 = dn1;
        ext_req = 2'b11;
        wait_both(b0, b1, 1'b1, 1'b1);
        ext_req = 2'b00;
        chk(owner_seq() == 6'b101010, "R5 rotating order", owner_seq(), 6'b101010);

        // Rotating priority with burst: a burst keeps the bus (R6)
        wr(4'h0, 32'h00); wr(4'h1, 32'h60); wr(4'h2, 32'd3); wr(4'h3, 32'h7);
        wr(4'h8, 32'h10); wr(4'h9, 32'hE0); wr(4'hA, 32'd3); wr(4'hB, 32'h7);
        wr_beats = 0; b0 = dn0; b1 = dn1;
        ext_req = 2'b11;
        wait_both(b0, b1, 1'b1, 1'b1);
        ext_req = 2'b00;
        chk(owner_seq() == 6'b111000, "R6 burst holds bus", owner_seq(), 6'b111000);
        wr(4'h4, 32'h2); wr(4'hC, 32'h2);

        // Stalled memory: count waits for the write handshake (R11)
        wait_cfg = 40;
        wr(4'h7, 32'h0);
        wr(4'h0, 32'h20); wr(4'h1, 32'h70); wr(4'h2, 32'd1); wr(4'h3, 32'h1);
        b0 = dn0;
        wr(4'h4, 32'h1);
        repeat (10) @(negedge clk);
        chk(bus_valid == 1'b1, "R11 cycle held while not ready", bus_valid, 1);
        rd(4'h2, d); chk(d == 1, "R11 count held during stall", d, 1);
        wait_both(b0, 0, 1'b1, 1'b0);
        rd(4'h2, d); chk(d == 0, "R11 count after handshake", d, 0);
        wait_cfg = 0;

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run is reported as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule